// File: doc/BRIEF.md
# Synchronous Burst ROM Read Controller

This block sits between a requester (processor or DMA engine) and a clock-synchronous burst ROM. A request carries an address, an access size, a write flag and write data. The external bus width is set by a configuration input. Every read is run as a complete fixed-length burst: 8 beats on a 16-bit bus, 4 beats on a 32-bit bus. This holds whatever size was asked for. The controller keeps the beats the request needs and drops the padding beats. The first beat waits a programmable 4-bit number of cycles and can be stretched further by the ROM's wait input. Each later beat waits a separate 2-bit number of cycles, and the wait input has no effect on those beats. Writes never burst: they run one plain access.

The state machine has these states:
- `ST_IDLE`: ready for a request.
- `ST_T1`: address and bus-start cycle.
- `ST_TW`: first-access wait.
- `ST_T2B`: burst data beat.
- `ST_TWB`: wait before a later beat.
- `ST_T2`: final data beat.
- `ST_WT1`, `ST_WTW`, `ST_WT2`: write start, write wait and write strobe.
- `ST_CFGERR`: unsupported bus width.

The state machine follows these transitions:
- IDLE→T1 on an accepted read.
- IDLE→WT1 on an accepted write.
- IDLE→CFGERR on a read with a bad width.
- T1→TW, or T1→T2B when there is no wait count and the wait input is low.
- TW→TW while the count runs or the wait input is high, then TW→T2B.
- T2B→TWB when the beat wait is non-zero.
- T2B→T2B or T2B→T2 when the beat wait is zero.
- TWB→TWB while its count runs, then TWB→T2B, or TWB→T2 for the last beat.
- T2→IDLE.
- WT1→WTW or WT1→WT2.
- WTW→WT2.
- WT2→IDLE.
- CFGERR→IDLE.

The requester sees the result on a one-cycle done pulse. The line output holds the captured beats, packed from bit 0 upward in address order.

Top module: `brom_burst_ctrl`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high only in IDLE, so it is low from the cycle after acceptance until the done pulse has been given.
- R2: The bus-width codes are 1 for a 16-bit bus and 2 for a 32-bit bus. Every read runs a full burst: 8 data beats on the 16-bit bus and 4 on the 32-bit bus. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 16 bytes; the size does not change the burst length.
- R3: The first beat is preceded by `cfg_first_wait` wait cycles (0 to 15). With the wait input low, a read holds `rom_cs_n` low for 1 + F + N + (N-1)·B cycles, where F is the first-access wait, N the beat count and B the beat wait.
- R4: Each later beat is preceded by `cfg_beat_wait` wait cycles (0 to 3).
- R5: `rom_bs_n` is low for exactly one cycle per access: the first cycle (T1).
- R6: If `rom_wait` is high at the end of a first-access wait cycle once the count is spent, or at the end of T1 when the count is zero, the first access is stretched. The first-access wait then lasts until the first cycle that ends with `rom_wait` low.
- R7: `rom_wait` has no effect after the first data beat. The read length and data are the same as with `rom_wait` held low.
- R8: A read with bus-width code 0 (8-bit) or 3 (reserved) runs no bus cycle, because `rom_cs_n` stays high. It gives the done pulse two cycles after acceptance with `rsp_cfg_err` high.
- R9: A write runs one access: T1, then the first-access waits (honouring `rom_wait`), then one strobe cycle. It takes 1 + F + 1 cycles. `rom_we_n` is low in the wait and strobe cycles and `rom_rd_n` stays high. `rom_addr` carries the request address unchanged and `rom_dout` carries the write data.
- R10: Read beats start at the request address rounded down to the bus width, and the address steps up by the bus width per beat. Beat k is sampled at the end of its data cycle into line bits [k·W +: W], where W is the bus width in bits. The beats kept are the first ceil(size/bus bytes), and the rest of the line reads zero. A 16-byte request keeps every beat.
- R11: `rom_cs_n` and `rom_rd_n` stay low without a break from T1 through T2. `rsp_done` is a one-cycle pulse in the cycle after the last bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R2) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| cfg_bus_w | input | 2 | Bus width code (R2, R8) |
| cfg_first_wait | input | FW_W | Wait cycles before the first beat |
| cfg_beat_wait | input | BW_W | Wait cycles before each later beat |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_cfg_err | output | 1 | Bad bus width, valid with `rsp_done` |
| rsp_rdata | output | LINE_BYTES·8 | Assembled read line |
| rom_cs_n | output | 1 | Chip select, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_bs_n | output | 1 | Bus-start strobe, active low |
| rom_we_n | output | 1 | Write strobe, active low |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_dout | output | DATA_W | Write data to the bus |
| rom_din | input | DATA_W | Read data from the ROM; low half used on a 16-bit bus |
| rom_wait | input | 1 | External wait request, active high |

## Verification
The bench runs short reads through full-length bursts and checks that the padding beats leave zero in the line. A controller that ended the burst early would show a short `rom_cs_n` window. A controller that kept padding would show non-zero upper line bits. The wait input is held high during the later beats to catch a design that stalls there. It is also stretched past the first-access count, including with a count of zero, to catch a design that samples it too late or too early. Finally, the bench sends an unaligned short read, an 8-bit or reserved width, and a write. These catch bad address rounding, a bus cycle started on an error, or a write that bursts or asserts the read strobe.

// File: rtl/brom_pkg.sv
package brom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_T1,
        ST_TW,
        ST_T2B,
        ST_TWB,
        ST_T2,
        ST_WT1,
        ST_WTW,
        ST_WT2,
        ST_CFGERR
    } brom_state_e;

    localparam logic [1:0] BUSW_8    = 2'd0;
    localparam logic [1:0] BUSW_16   = 2'd1;
    localparam logic [1:0] BUSW_32   = 2'd2;
    localparam logic [1:0] BUSW_RSVD = 2'd3;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_LINE = 2'd3;

endpackage

// File: rtl/brom_wait_ctr.sv
module brom_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign is_zero = (cnt_q == '0);

    // R3: the sequencer never asks for a decrement once the count is spent
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/brom_beat_ctr.sv
module brom_beat_ctr #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 3,
    parameter int WIDE_STEP  = 4,
    parameter int NARROW_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wide,
    input  logic              adv,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            addr_q <= '0;
            wide_q <= 1'b0;
        end else if (start) begin
            idx_q  <= '0;
            addr_q <= start_addr;
            wide_q <= wide;
        end else if (adv) begin
            idx_q  <= idx_q + 1'b1;
            addr_q <= addr_q + (wide_q ? ADDR_W'(WIDE_STEP) : ADDR_W'(NARROW_STEP));
        end
    end

    assign idx  = idx_q;
    assign addr = addr_q;

    // R10: each advance moves the address by exactly one bus width
    a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !start) |=> ((addr_q - $past(addr_q)) ==
                             (wide_q ? ADDR_W'(WIDE_STEP) : ADDR_W'(NARROW_STEP))));

endmodule

// File: rtl/brom_assemble.sv
module brom_assemble #(
    parameter int DATA_W = 32,
    parameter int LINE_W = 128,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              wide,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W:0]    keep_n,
    input  logic [DATA_W-1:0] din,
    output logic [LINE_W-1:0] line
);

    localparam int HALF_W = DATA_W / 2;
    localparam int NSLOT  = LINE_W / HALF_W;

    logic [HALF_W-1:0] slot_q [NSLOT];
    logic              keep_beat;

    assign keep_beat = capture && ({1'b0, idx} < keep_n);

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic hit;
        logic [HALF_W-1:0] src;
        assign hit = wide ? (int'(idx) == k / 2) : (int'(idx) == k);
        assign src = wide ? din[(k % 2) * HALF_W +: HALF_W] : din[HALF_W-1:0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[k] <= '0;
            end else if (clear) begin
                slot_q[k] <= '0;
            end else if (keep_beat && hit) begin
                slot_q[k] <= src;
            end
        end

        assign line[k * HALF_W +: HALF_W] = slot_q[k];
    end

    // R2: on the wide bus only the first LINE_W/DATA_W beat slots exist
    a_r2_wide_index: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && wide) |-> (int'(idx) < LINE_W / DATA_W));

endmodule

// File: rtl/brom_burst_ctrl.sv
module brom_burst_ctrl
    import brom_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int FW_W       = 4,
    parameter int BW_W       = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [1:0]                cfg_bus_w,
    input  logic [FW_W-1:0]           cfg_first_wait,
    input  logic [BW_W-1:0]           cfg_beat_wait,
    output logic                      rsp_done,
    output logic                      rsp_cfg_err,
    output logic [LINE_BYTES*8-1:0]   rsp_rdata,
    output logic                      rom_cs_n,
    output logic                      rom_rd_n,
    output logic                      rom_bs_n,
    output logic                      rom_we_n,
    output logic [ADDR_W-1:0]         rom_addr,
    output logic [DATA_W-1:0]         rom_dout,
    input  logic [DATA_W-1:0]         rom_din,
    input  logic                      rom_wait
);

    localparam int LINE_W       = LINE_BYTES * 8;
    localparam int HALF_W       = DATA_W / 2;
    localparam int WIDE_BYTES   = DATA_W / 8;
    localparam int NARROW_BYTES = HALF_W / 8;
    localparam int BEATS_WIDE   = LINE_W / DATA_W;
    localparam int BEATS_NARROW = LINE_W / HALF_W;
    localparam int IDX_W        = $clog2(BEATS_NARROW);

    brom_state_e state_q, state_d;

    logic              accept;
    logic              wr_q, wide_q;
    logic [FW_W-1:0]   fw_q;
    logic [BW_W-1:0]   bw_q;
    logic [IDX_W:0]    keep_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  last_idx;
    logic              done_q, err_q;

    logic              wc_load, wc_dec, wc_zero;
    logic [FW_W-1:0]   wc_val, wc_cnt;
    logic [IDX_W-1:0]  beat_idx;
    logic [ADDR_W-1:0] beat_addr, start_addr;
    logic              req_wide, bus_ok;

    function automatic logic [IDX_W:0] keep_beats(input logic [1:0] sz, input logic wd);
        int bytes;
        int per;
        unique case (sz)
            SZ_BYTE: bytes = 1;
            SZ_HALF: bytes = 2;
            SZ_WORD: bytes = 4;
            default: bytes = LINE_BYTES;
        endcase
        per = wd ? WIDE_BYTES : NARROW_BYTES;
        return (IDX_W+1)'((bytes + per - 1) / per);
    endfunction

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign req_wide = (cfg_bus_w == BUSW_32);
    assign bus_ok   = (cfg_bus_w == BUSW_16) || (cfg_bus_w == BUSW_32);
    assign last_idx = wide_q ? IDX_W'(BEATS_WIDE - 1) : IDX_W'(BEATS_NARROW - 1);

    always_comb begin
        if (req_write) begin
            start_addr = req_addr;
        end else if (req_wide) begin
            start_addr = req_addr & ~ADDR_W'(WIDE_BYTES - 1);
        end else begin
            start_addr = req_addr & ~ADDR_W'(NARROW_BYTES - 1);
        end
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            fw_q    <= '0;
            bw_q    <= '0;
            keep_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            wide_q  <= req_wide;
            fw_q    <= cfg_first_wait;
            bw_q    <= cfg_beat_wait;
            keep_q  <= keep_beats(req_size, req_wide);
            wdata_q <= req_wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write)    state_d = ST_WT1;
                    else if (!bus_ok) state_d = ST_CFGERR;
                    else              state_d = ST_T1;
                end
            end
            ST_T1:  state_d = (fw_q == '0 && !rom_wait) ? ST_T2B : ST_TW;
            ST_TW:  if (wc_zero && !rom_wait) state_d = ST_T2B;
            ST_T2B: begin
                if (bw_q != '0)                     state_d = ST_TWB;
                else if (beat_idx + 1'b1 == last_idx) state_d = ST_T2;
                else                                state_d = ST_T2B;
            end
            ST_TWB: if (wc_zero) state_d = (beat_idx == last_idx) ? ST_T2 : ST_T2B;
            ST_T2:  state_d = ST_IDLE;
            ST_WT1: state_d = (fw_q == '0 && !rom_wait) ? ST_WT2 : ST_WTW;
            ST_WTW: if (wc_zero && !rom_wait) state_d = ST_WT2;
            ST_WT2: state_d = ST_IDLE;
            ST_CFGERR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        rom_cs_n = 1'b1;
        rom_rd_n = 1'b1;
        rom_bs_n = 1'b1;
        rom_we_n = 1'b1;
        unique case (state_q)
            ST_T1:  begin rom_cs_n = 1'b0; rom_rd_n = 1'b0; rom_bs_n = 1'b0; end
            ST_TW, ST_T2B, ST_TWB, ST_T2: begin
                rom_cs_n = 1'b0; rom_rd_n = 1'b0;
            end
            ST_WT1: begin rom_cs_n = 1'b0; rom_bs_n = 1'b0; end
            ST_WTW, ST_WT2: begin rom_cs_n = 1'b0; rom_we_n = 1'b0; end
            default: ;
        endcase
    end

    // wait counter control
    assign wc_load = (state_q == ST_T1) || (state_q == ST_WT1) ||
                     (state_q == ST_T2B && bw_q != '0);
    assign wc_val  = (state_q == ST_T2B) ? (FW_W'(bw_q) - 1'b1) :
                     ((fw_q == '0) ? '0 : fw_q - 1'b1);
    assign wc_dec  = ((state_q == ST_TW) || (state_q == ST_WTW) ||
                      (state_q == ST_TWB)) && !wc_zero;

    brom_wait_ctr #(.W(FW_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wc_load),
        .load_val (wc_val),
        .dec      (wc_dec),
        .cnt      (wc_cnt),
        .is_zero  (wc_zero)
    );

    brom_beat_ctr #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .WIDE_STEP   (WIDE_BYTES),
        .NARROW_STEP (NARROW_BYTES)
    ) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_addr (start_addr),
        .wide       (req_wide),
        .adv        (state_q == ST_T2B),
        .idx        (beat_idx),
        .addr       (beat_addr)
    );

    brom_assemble #(
        .DATA_W (DATA_W),
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture ((state_q == ST_T2B) || (state_q == ST_T2)),
        .wide    (wide_q),
        .idx     (beat_idx),
        .keep_n  (keep_q),
        .din     (rom_din),
        .line    (rsp_rdata)
    );

    // completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_T2) || (state_q == ST_WT2) || (state_q == ST_CFGERR);
            err_q  <= (state_q == ST_CFGERR);
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_done    = done_q;
    assign rsp_cfg_err = err_q;
    assign rom_addr    = beat_addr;
    assign rom_dout    = wdata_q;

    // R1: one request in flight
    a_r1_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: bus start lasts a single cycle
    a_r5_bs_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_bs_n |=> rom_bs_n);

    // R11: done is a pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: an error completion follows a cycle with no chip select
    a_r8_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cfg_err |-> (rsp_done && $past(rom_cs_n)));

    // R2: the final beat is the last one of the burst
    a_r2_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2) |-> (beat_idx == last_idx));

    // R4 / R7: a spent beat-wait count always moves to data, whatever rom_wait does
    a_r7_beat_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWB && wc_zero) |=> (state_q == ST_T2B || state_q == ST_T2));

    // R9: a write never asserts the read strobe
    a_r9_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_we_n |-> rom_rd_n);

endmodule

// File: tb/brom_burst_ctrl_tb.sv
`timescale 1ns/1ps
module brom_burst_ctrl_tb;

    typedef struct packed {
        logic [1:0]  size;
        logic [1:0]  bus;
        logic [3:0]  fw;
        logic [1:0]  bw;
        logic [31:0] addr;
        logic [3:0]  ext;
        logic        late;
    } vec_t;

    // size, bus, first wait, beat wait, address, first-access stretch, late wait
    localparam vec_t VECS [7] = '{
        '{2'd2, 2'd1, 4'd2,  2'd1, 32'h0000_0100, 4'd0, 1'b0},
        '{2'd3, 2'd2, 4'd0,  2'd0, 32'h0000_2000, 4'd0, 1'b0},
        '{2'd0, 2'd2, 4'd15, 2'd3, 32'h0000_3003, 4'd0, 1'b0},
        '{2'd1, 2'd1, 4'd1,  2'd2, 32'h0000_4006, 4'd0, 1'b0},
        '{2'd3, 2'd1, 4'd3,  2'd0, 32'h0000_0500, 4'd6, 1'b0},
        '{2'd2, 2'd2, 4'd1,  2'd1, 32'h0000_060C, 4'd0, 1'b1},
        '{2'd3, 2'd2, 4'd0,  2'd2, 32'h0000_0700, 4'd3, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = '0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [1:0]   cfg_bus_w = 2'd1;
    logic [3:0]   cfg_first_wait = '0;
    logic [1:0]   cfg_beat_wait = '0;
    logic         rsp_done, rsp_cfg_err;
    logic [127:0] rsp_rdata;
    logic         rom_cs_n, rom_rd_n, rom_bs_n, rom_we_n;
    logic [31:0]  rom_addr, rom_dout, rom_din;
    logic         rom_wait;

    logic [3:0]   ext_q = '0;
    logic         late_en = 1'b0;
    logic [31:0]  first_addr = '0;

    int checks = 0;
    int errors = 0;

    // per-transaction observations
    int n_cyc, n_cs, n_bs, n_rd, n_we, n_ready_busy, n_wr_bad;
    logic got_err, done_again;
    logic [127:0] got_line;

    always #4 clk = ~clk;

    assign rom_din  = {~rom_addr[15:0], rom_addr[15:0]};
    assign rom_wait = (ext_q != '0) || (late_en && !rom_cs_n && rom_addr != first_addr);

    always @(posedge clk) begin
        if (!rom_cs_n && ext_q != '0) ext_q <= ext_q - 1'b1;
    end

    brom_burst_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_write      (req_write),
        .req_size       (req_size),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .cfg_bus_w      (cfg_bus_w),
        .cfg_first_wait (cfg_first_wait),
        .cfg_beat_wait  (cfg_beat_wait),
        .rsp_done       (rsp_done),
        .rsp_cfg_err    (rsp_cfg_err),
        .rsp_rdata      (rsp_rdata),
        .rom_cs_n       (rom_cs_n),
        .rom_rd_n       (rom_rd_n),
        .rom_bs_n       (rom_bs_n),
        .rom_we_n       (rom_we_n),
        .rom_addr       (rom_addr),
        .rom_dout       (rom_dout),
        .rom_din        (rom_din),
        .rom_wait       (rom_wait)
    );

    task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [1:0] sz, input logic [1:0] bus,
                           input logic [3:0] fw, input logic [1:0] bw,
                           input logic [31:0] addr, input logic [31:0] wd,
                           input logic [3:0] ext, input logic late,
                           input logic [31:0] base);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
        req_wdata = wd; cfg_bus_w = bus; cfg_first_wait = fw; cfg_beat_wait = bw;
        ext_q = ext; late_en = late; first_addr = base;
        n_cyc = 0; n_cs = 0; n_bs = 0; n_rd = 0; n_we = 0; n_ready_busy = 0; n_wr_bad = 0;
        got_err = 1'b0; got_line = '0;
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            n_cyc++;
            if (rsp_done) begin
                got_err = rsp_cfg_err;
                got_line = rsp_rdata;
                break;
            end
            if (!rom_cs_n) n_cs++;
            if (!rom_bs_n) n_bs++;
            if (!rom_rd_n) n_rd++;
            if (!rom_we_n) begin
                n_we++;
                if (rom_addr != addr || rom_dout != wd) n_wr_bad++;
            end
            if (req_ready) n_ready_busy++;
            if (n_cyc > 2000) break;
        end
        @(negedge clk);
        done_again = rsp_done;
        late_en = 1'b0;
    endtask

    function automatic int beats_of(input logic [1:0] bus);
        return (bus == 2'd2) ? 4 : 8;
    endfunction

    function automatic int keep_of(input logic [1:0] sz, input logic [1:0] bus);
        int bytes;
        int per;
        bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 16;
        per = (bus == 2'd2) ? 4 : 2;
        return (bytes + per - 1) / per;
    endfunction

    function automatic logic [31:0] base_of(input logic [31:0] a, input logic [1:0] bus);
        return (bus == 2'd2) ? {a[31:2], 2'b00} : {a[31:1], 1'b0};
    endfunction

    function automatic logic [127:0] line_of(input vec_t v);
        logic [127:0] l;
        logic [31:0] a;
        l = '0;
        for (int k = 0; k < keep_of(v.size, v.bus); k++) begin
            if (v.bus == 2'd2) begin
                a = base_of(v.addr, v.bus) + 32'(4 * k);
                l[32*k +: 32] = {~a[15:0], a[15:0]};
            end else begin
                a = base_of(v.addr, v.bus) + 32'(2 * k);
                l[16*k +: 16] = a[15:0];
            end
        end
        return l;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int exp_len;
        int nb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state (R1, R11)
        chk(req_ready === 1'b1, "R1 ready in reset", 128'(req_ready), 128'd1);
        chk({rom_cs_n, rom_rd_n, rom_bs_n, rom_we_n} === 4'hF, "R11 strobes idle in reset",
            128'({rom_cs_n, rom_rd_n, rom_bs_n, rom_we_n}), 128'hF);
        chk(rsp_done === 1'b0, "R11 no done in reset", 128'(rsp_done), 128'd0);
        rst_n = 1'b1;

        // table of reads (R2, R3, R4, R5, R6, R7, R10, R11)
        for (int i = 0; i < 7; i++) begin
            vec_t v;
            v = VECS[i];
            nb = beats_of(v.bus);
            exp_len = 1 + ((int'(v.ext) > int'(v.fw)) ? int'(v.ext) : int'(v.fw))
                      + nb + (nb - 1) * int'(v.bw);
            run_txn(1'b0, v.size, v.bus, v.fw, v.bw, v.addr, 32'h0, v.ext, v.late,
                    base_of(v.addr, v.bus));
            chk(n_cs == exp_len, $sformatf("R3 R4 R6 R7 cs window vec %0d", i),
                128'(n_cs), 128'(exp_len));
            chk(n_rd == exp_len, $sformatf("R11 rd window vec %0d", i),
                128'(n_rd), 128'(exp_len));
            chk(n_cyc == exp_len + 1, $sformatf("R11 done timing vec %0d", i),
                128'(n_cyc), 128'(exp_len + 1));
            chk(n_bs == 1, $sformatf("R5 bs count vec %0d", i), 128'(n_bs), 128'd1);
            chk(got_line == line_of(v), $sformatf("R2 R10 line vec %0d", i),
                got_line, line_of(v));
            chk(!got_err && !done_again, $sformatf("R11 pulse/no err vec %0d", i),
                128'({got_err, done_again}), 128'd0);
            chk(n_ready_busy == 0, $sformatf("R1 busy ready vec %0d", i),
                128'(n_ready_busy), 128'd0);
        end

        // R8: 8-bit width rejected without a bus cycle
        run_txn(1'b0, 2'd2, 2'd0, 4'd2, 2'd1, 32'h100, 32'h0, 4'd0, 1'b0, 32'h100);
        chk(got_err && n_cyc == 2, "R8 8-bit error", 128'({got_err, 8'(n_cyc)}), 128'h1_02);
        chk(n_cs == 0, "R8 8-bit no chip select", 128'(n_cs), 128'd0);
        // R8: reserved width code
        run_txn(1'b0, 2'd3, 2'd3, 4'd0, 2'd0, 32'h200, 32'h0, 4'd0, 1'b0, 32'h200);
        chk(got_err && n_cs == 0, "R8 reserved width", 128'({got_err, 8'(n_cs)}), 128'h1_00);

        // R9: plain write, no stretch
        run_txn(1'b1, 2'd0, 2'd1, 4'd2, 2'd3, 32'h7001, 32'hDEAD_BEEF, 4'd0, 1'b0, 32'h7001);
        chk(n_cs == 4 && n_cyc == 5, "R9 write length", 128'({8'(n_cs), 8'(n_cyc)}),
            128'h04_05);
        chk(n_we == 3 && n_rd == 0 && n_bs == 1, "R9 write strobes",
            128'({8'(n_we), 8'(n_rd), 8'(n_bs)}), 128'h03_00_01);
        chk(n_wr_bad == 0 && !got_err, "R9 write addr/data", 128'(n_wr_bad), 128'd0);
        // R9 with R6: write stretched by the wait input with zero count
        run_txn(1'b1, 2'd2, 2'd2, 4'd0, 2'd0, 32'h7100, 32'h1234_5678, 4'd2, 1'b0, 32'h7100);
        chk(n_cs == 4 && n_we == 3, "R9 R6 write stretch", 128'({8'(n_cs), 8'(n_we)}),
            128'h04_03);

        // R1: request held while busy is taken only once
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = 32'h800;
        cfg_bus_w = 2'd2; cfg_first_wait = 4'd0; cfg_beat_wait = 2'd0;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 ready drops after accept", 128'(req_ready), 128'd0);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready back after burst", 128'(req_ready), 128'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule